// File: doc/BRIEF.md
# Real-Mode Segmented Address Generator

This block forms the 20-bit physical address of one memory access for a 16-bit processor that runs in real mode. For each request it picks the offset source from the access kind: the instruction pointer for a fetch, the stack pointer for a push or pop, the destination index for a string store, or a sum of base register, index register and displacement for a data operand. It also picks a segment register, either the default for the access or one named by an override. It then shifts the segment left by four bits and adds the offset.

The surrounding decode logic presents the register values, the addressing-mode code and a one-cycle `req_i` pulse. The result comes back one cycle later with `valid_o`. The effective offset, the segment that was chosen (its code and its value) and the physical address stay on the outputs until the next request. `mem_req_o` marks results that actually address memory. Register and immediate operands produce no address.

Top module: `rm_addr_gen`

## Requirements
- R1: `phys_o` equals the selected segment value with four zero bits appended on the right, plus the zero-extended offset, taken modulo 2^20. C000h:1C78h gives C1C78h, and FFFFh:0010h gives 00000h.
- R2: The offset sum of base, index and displacement wraps modulo 2^16 before the segment is added. Offset parts F000h and 3000h with segment 4000h give offset 2000h and address 42000h.
- R3: For a data access (`acc_i`=2), `mode_i` selects the offset terms as follows. 2 is direct (displacement only). 3 is indirect: the index register when `ind_idx_i`=1, otherwise the base register. 4 is base plus displacement. 5 is index plus displacement. 6 is base plus index. 7 is base plus index plus displacement. The base register is BP when `base_bp_i`=1 and BX otherwise. The index register is DI when `idx_di_i`=1 and SI otherwise.
- R4: When `disp_wide_i`=0, only bits 7:0 of `disp_i` are used, sign-extended to 16 bits. When `disp_wide_i`=1, all 16 bits are used as given.
- R5: A fetch (`acc_i`=0) addresses CS:IP, whatever the override inputs hold.
- R6: A stack access (`acc_i`=1) addresses SS:SP, whatever the override inputs hold.
- R7: A string destination access (`acc_i`=3) addresses ES:DI, whatever the override inputs hold.
- R8: With no override, a data memory mode whose offset includes the base register with BP selected defaults to SS. Every other data memory mode defaults to DS.
- R9: When `ovr_en_i`=1, a data memory access uses the segment coded on `ovr_sel_i` instead of the default. The segment code is 0=ES, 1=CS, 2=SS, 3=DS, and the same code appears on `seg_id_o`.
- R10: Data modes 0 (register) and 1 (immediate) leave `mem_req_o` low and return zero on `offset_o`, `seg_id_o`, `seg_val_o` and `phys_o`.
- R11: `valid_o` is high exactly in the cycle after a cycle with `req_i` high. `mem_req_o` is high only together with `valid_o`. Without a request, the offset, segment and address outputs keep their values.
- R12: While reset is active, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | 1 | Compute an address from the current inputs |
| acc_i | input | 2 | Access kind: 0 fetch, 1 stack, 2 data, 3 string destination |
| mode_i | input | 3 | Operand addressing mode for data accesses |
| base_bp_i | input | 1 | Base register is BP (1) or BX (0) |
| idx_di_i | input | 1 | Index register is DI (1) or SI (0) |
| ind_idx_i | input | 1 | Indirect mode uses the index register (1) or the base register (0) |
| disp_i | input | 16 | Displacement |
| disp_wide_i | input | 1 | Displacement is 16-bit (1) or 8-bit (0) |
| bx_i | input | 16 | BX value |
| bp_i | input | 16 | BP value |
| si_i | input | 16 | SI value |
| di_i | input | 16 | DI value |
| sp_i | input | 16 | Stack pointer value |
| ip_i | input | 16 | Instruction pointer value |
| es_i | input | 16 | ES value |
| cs_i | input | 16 | CS value |
| ss_i | input | 16 | SS value |
| ds_i | input | 16 | DS value |
| ovr_en_i | input | 1 | Segment override present |
| ovr_sel_i | input | 2 | Override segment code |
| valid_o | output | 1 | Result registered from the previous cycle's request |
| mem_req_o | output | 1 | Result addresses memory |
| offset_o | output | 16 | Effective offset |
| seg_id_o | output | 2 | Chosen segment code |
| seg_val_o | output | 16 | Chosen segment value |
| phys_o | output | 20 | Physical address |

## Verification
The assertions assume that `req_i` stays low until the internal reset synchroniser has released, which takes two clock edges after `rst_ni` rises. They also assume that every input holds a known value at each rising edge. The stimulus changes inputs only on falling edges and waits three cycles after each reset release before the first request. It draws access kinds, modes, register selects, displacement widths and override settings over their full ranges, so every segment default and override path occurs. It also places idle cycles with changed inputs between requests, so the output hold behaviour is exercised.

// File: rtl/rm_addr_pkg.sv
package rm_addr_pkg;

  typedef enum logic [1:0] {
    ACC_FETCH  = 2'd0,
    ACC_STACK  = 2'd1,
    ACC_DATA   = 2'd2,
    ACC_STRDST = 2'd3
  } acc_e;

  typedef enum logic [2:0] {
    MD_REG       = 3'd0,
    MD_IMM       = 3'd1,
    MD_DIRECT    = 3'd2,
    MD_INDIRECT  = 3'd3,
    MD_BASED     = 3'd4,
    MD_INDEXED   = 3'd5,
    MD_BIDX      = 3'd6,
    MD_BIDX_DISP = 3'd7
  } mode_e;

  typedef enum logic [1:0] {
    SEG_ES = 2'd0,
    SEG_CS = 2'd1,
    SEG_SS = 2'd2,
    SEG_DS = 2'd3
  } seg_e;

  localparam int unsigned NUM_SEG = 4;

endpackage

// File: rtl/rm_addr_rst_sync.sv
module rm_addr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb sync_d = 1'b1;
    end else begin : g_chain
      always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/rm_addr_offset.sv
module rm_addr_offset
  import rm_addr_pkg::*;
#(
  parameter int unsigned OFS_W        = 16,
  parameter int unsigned DISP_SHORT_W = 8
) (
  input  logic [1:0]       acc_i,
  input  logic [2:0]       mode_i,
  input  logic             base_bp_i,
  input  logic             idx_di_i,
  input  logic             ind_idx_i,
  input  logic [OFS_W-1:0] disp_i,
  input  logic             disp_wide_i,
  input  logic [OFS_W-1:0] bx_i,
  input  logic [OFS_W-1:0] bp_i,
  input  logic [OFS_W-1:0] si_i,
  input  logic [OFS_W-1:0] di_i,
  input  logic [OFS_W-1:0] sp_i,
  input  logic [OFS_W-1:0] ip_i,
  output logic [OFS_W-1:0] offset_o,
  output logic             mem_o,
  output logic             bp_ref_o
);

  localparam int unsigned EXT_W = OFS_W - DISP_SHORT_W;

  logic [OFS_W-1:0] disp_ext;
  logic [OFS_W-1:0] base_val;
  logic [OFS_W-1:0] idx_val;
  logic [OFS_W-1:0] base_term;
  logic [OFS_W-1:0] idx_term;
  logic [OFS_W-1:0] disp_term;
  logic             use_base;
  logic             use_idx;
  logic             use_disp;

  // Short displacements carry their sign into the upper bits.
  always_comb begin
    if (disp_wide_i) begin
      disp_ext = disp_i;
    end else begin
      disp_ext = {{EXT_W{disp_i[DISP_SHORT_W-1]}}, disp_i[DISP_SHORT_W-1:0]};
    end
  end

  assign base_val = base_bp_i ? bp_i : bx_i;
  assign idx_val  = idx_di_i  ? di_i : si_i;

  // Which terms a data mode adds together.
  always_comb begin
    use_base = 1'b0;
    use_idx  = 1'b0;
    use_disp = 1'b0;
    unique case (mode_e'(mode_i))
      MD_REG, MD_IMM: ;
      MD_DIRECT:    use_disp = 1'b1;
      MD_INDIRECT: begin
        use_base = !ind_idx_i;
        use_idx  = ind_idx_i;
      end
      MD_BASED: begin
        use_base = 1'b1;
        use_disp = 1'b1;
      end
      MD_INDEXED: begin
        use_idx  = 1'b1;
        use_disp = 1'b1;
      end
      MD_BIDX: begin
        use_base = 1'b1;
        use_idx  = 1'b1;
      end
      MD_BIDX_DISP: begin
        use_base = 1'b1;
        use_idx  = 1'b1;
        use_disp = 1'b1;
      end
      default: ;
    endcase
  end

  assign base_term = use_base ? base_val : '0;
  assign idx_term  = use_idx  ? idx_val  : '0;
  assign disp_term = use_disp ? disp_ext : '0;

  always_comb begin
    offset_o = '0;
    mem_o    = 1'b1;
    bp_ref_o = 1'b0;
    unique case (acc_e'(acc_i))
      ACC_FETCH:  offset_o = ip_i;
      ACC_STACK:  offset_o = sp_i;
      ACC_STRDST: offset_o = di_i;
      ACC_DATA: begin
        mem_o    = use_base | use_idx | use_disp;
        // OFS_W-bit sum: the carry out is dropped, giving modulo wrap.
        offset_o = base_term + idx_term + disp_term;
        bp_ref_o = use_base & base_bp_i;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/rm_addr_segsel.sv
module rm_addr_segsel
  import rm_addr_pkg::*;
#(
  parameter int unsigned SEG_W = 16
) (
  input  logic [1:0]       acc_i,
  input  logic             bp_ref_i,
  input  logic             ovr_en_i,
  input  logic [1:0]       ovr_sel_i,
  input  logic [SEG_W-1:0] es_i,
  input  logic [SEG_W-1:0] cs_i,
  input  logic [SEG_W-1:0] ss_i,
  input  logic [SEG_W-1:0] ds_i,
  output logic [1:0]       seg_id_o,
  output logic [SEG_W-1:0] seg_val_o
);

  logic [SEG_W-1:0] seg_tab [NUM_SEG];
  seg_e             sel;

  assign seg_tab[SEG_ES] = es_i;
  assign seg_tab[SEG_CS] = cs_i;
  assign seg_tab[SEG_SS] = ss_i;
  assign seg_tab[SEG_DS] = ds_i;

  always_comb begin
    unique case (acc_e'(acc_i))
      ACC_FETCH:  sel = SEG_CS;
      ACC_STACK:  sel = SEG_SS;
      ACC_STRDST: sel = SEG_ES;
      ACC_DATA: begin
        if (ovr_en_i) begin
          sel = seg_e'(ovr_sel_i);
        end else if (bp_ref_i) begin
          sel = SEG_SS;
        end else begin
          sel = SEG_DS;
        end
      end
      default: sel = SEG_DS;
    endcase
  end

  assign seg_id_o  = sel;
  assign seg_val_o = seg_tab[sel];

endmodule

// File: rtl/rm_addr_phys.sv
module rm_addr_phys #(
  parameter int unsigned OFS_W     = 16,
  parameter int unsigned SEG_SHIFT = 4
) (
  input  logic [OFS_W-1:0]           seg_val_i,
  input  logic [OFS_W-1:0]           offset_i,
  output logic [OFS_W+SEG_SHIFT-1:0] phys_o
);

  localparam int unsigned PA_W = OFS_W + SEG_SHIFT;

  logic [PA_W-1:0] seg_base;
  logic [PA_W-1:0] ofs_ext;

  assign seg_base = {seg_val_i, {SEG_SHIFT{1'b0}}};
  assign ofs_ext  = {{SEG_SHIFT{1'b0}}, offset_i};
  // PA_W-bit result: the carry past the top bit is discarded.
  assign phys_o   = seg_base + ofs_ext;

endmodule

// File: rtl/rm_addr_gen.sv
module rm_addr_gen #(
  parameter int unsigned OFS_W        = 16,
  parameter int unsigned SEG_SHIFT    = 4,
  parameter int unsigned DISP_SHORT_W = 8,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_i,
  input  logic [1:0]                 acc_i,
  input  logic [2:0]                 mode_i,
  input  logic                       base_bp_i,
  input  logic                       idx_di_i,
  input  logic                       ind_idx_i,
  input  logic [OFS_W-1:0]           disp_i,
  input  logic                       disp_wide_i,
  input  logic [OFS_W-1:0]           bx_i,
  input  logic [OFS_W-1:0]           bp_i,
  input  logic [OFS_W-1:0]           si_i,
  input  logic [OFS_W-1:0]           di_i,
  input  logic [OFS_W-1:0]           sp_i,
  input  logic [OFS_W-1:0]           ip_i,
  input  logic [OFS_W-1:0]           es_i,
  input  logic [OFS_W-1:0]           cs_i,
  input  logic [OFS_W-1:0]           ss_i,
  input  logic [OFS_W-1:0]           ds_i,
  input  logic                       ovr_en_i,
  input  logic [1:0]                 ovr_sel_i,
  output logic                       valid_o,
  output logic                       mem_req_o,
  output logic [OFS_W-1:0]           offset_o,
  output logic [1:0]                 seg_id_o,
  output logic [OFS_W-1:0]           seg_val_o,
  output logic [OFS_W+SEG_SHIFT-1:0] phys_o
);

  localparam int unsigned PA_W = OFS_W + SEG_SHIFT;

  logic             rst_sync_n;
  logic [OFS_W-1:0] ofs_c;
  logic             mem_c;
  logic             bp_ref_c;
  logic [1:0]       sid_c;
  logic [OFS_W-1:0] sval_c;
  logic [PA_W-1:0]  pa_c;

  logic             valid_d, valid_q;
  logic             memreq_d, memreq_q;
  logic             cap_en;
  logic [OFS_W-1:0] ofs_d, ofs_q;
  logic [1:0]       sid_d, sid_q;
  logic [OFS_W-1:0] sval_d, sval_q;
  logic [PA_W-1:0]  pa_d, pa_q;

  rm_addr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk_i   (clk_i),
    .arst_ni (rst_ni),
    .rst_no  (rst_sync_n)
  );

  rm_addr_offset #(.OFS_W(OFS_W), .DISP_SHORT_W(DISP_SHORT_W)) u_offset (
    .acc_i       (acc_i),
    .mode_i      (mode_i),
    .base_bp_i   (base_bp_i),
    .idx_di_i    (idx_di_i),
    .ind_idx_i   (ind_idx_i),
    .disp_i      (disp_i),
    .disp_wide_i (disp_wide_i),
    .bx_i        (bx_i),
    .bp_i        (bp_i),
    .si_i        (si_i),
    .di_i        (di_i),
    .sp_i        (sp_i),
    .ip_i        (ip_i),
    .offset_o    (ofs_c),
    .mem_o       (mem_c),
    .bp_ref_o    (bp_ref_c)
  );

  rm_addr_segsel #(.SEG_W(OFS_W)) u_segsel (
    .acc_i     (acc_i),
    .bp_ref_i  (bp_ref_c),
    .ovr_en_i  (ovr_en_i),
    .ovr_sel_i (ovr_sel_i),
    .es_i      (es_i),
    .cs_i      (cs_i),
    .ss_i      (ss_i),
    .ds_i      (ds_i),
    .seg_id_o  (sid_c),
    .seg_val_o (sval_c)
  );

  rm_addr_phys #(.OFS_W(OFS_W), .SEG_SHIFT(SEG_SHIFT)) u_phys (
    .seg_val_i (sval_c),
    .offset_i  (ofs_c),
    .phys_o    (pa_c)
  );

  // Next state: non-memory operands return an all-zero result.
  always_comb begin
    cap_en   = req_i;
    valid_d  = req_i;
    memreq_d = req_i & mem_c;
    ofs_d    = mem_c ? ofs_c  : '0;
    sid_d    = mem_c ? sid_c  : '0;
    sval_d   = mem_c ? sval_c : '0;
    pa_d     = mem_c ? pa_c   : '0;
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      valid_q  <= 1'b0;
      memreq_q <= 1'b0;
      ofs_q    <= '0;
      sid_q    <= '0;
      sval_q   <= '0;
      pa_q     <= '0;
    end else begin
      valid_q  <= valid_d;
      memreq_q <= memreq_d;
      if (cap_en) begin
        ofs_q  <= ofs_d;
        sid_q  <= sid_d;
        sval_q <= sval_d;
        pa_q   <= pa_d;
      end
    end
  end

  assign valid_o   = valid_q;
  assign mem_req_o = memreq_q;
  assign offset_o  = ofs_q;
  assign seg_id_o  = sid_q;
  assign seg_val_o = sval_q;
  assign phys_o    = pa_q;

endmodule

// File: rtl/rm_addr_gen_chk.sv
module rm_addr_gen_chk
  import rm_addr_pkg::*;
#(
  parameter int unsigned OFS_W     = 16,
  parameter int unsigned SEG_SHIFT = 4
) (
  input logic                       clk_i,
  input logic                       rst_sync_ni,
  input logic                       req_i,
  input logic [1:0]                 acc_i,
  input logic [2:0]                 mode_i,
  input logic [OFS_W-1:0]           ip_i,
  input logic [OFS_W-1:0]           sp_i,
  input logic [OFS_W-1:0]           di_i,
  input logic                       valid_o,
  input logic                       mem_req_o,
  input logic [OFS_W-1:0]           offset_o,
  input logic [1:0]                 seg_id_o,
  input logic [OFS_W-1:0]           seg_val_o,
  input logic [OFS_W+SEG_SHIFT-1:0] phys_o
);

  localparam int unsigned PA_W = OFS_W + SEG_SHIFT;

  logic armed_q;

  always_ff @(posedge clk_i or negedge rst_sync_ni) begin
    if (!rst_sync_ni) begin
      armed_q <= 1'b0;
    end else begin
      armed_q <= 1'b1;
    end
  end

  p_phys_sum_r1: assert property (@(posedge clk_i) disable iff (!rst_sync_ni)
    (valid_o && mem_req_o) |->
      (phys_o == ({seg_val_o, {SEG_SHIFT{1'b0}}} + {{SEG_SHIFT{1'b0}}, offset_o})));

  p_fetch_cs_ip_r5: assert property (@(posedge clk_i) disable iff (!rst_sync_ni)
    (armed_q && $past(req_i && (acc_i == ACC_FETCH))) |->
      (mem_req_o && (seg_id_o == SEG_CS) && (offset_o == $past(ip_i))));

  p_stack_ss_sp_r6: assert property (@(posedge clk_i) disable iff (!rst_sync_ni)
    (armed_q && $past(req_i && (acc_i == ACC_STACK))) |->
      (mem_req_o && (seg_id_o == SEG_SS) && (offset_o == $past(sp_i))));

  p_strdst_es_di_r7: assert property (@(posedge clk_i) disable iff (!rst_sync_ni)
    (armed_q && $past(req_i && (acc_i == ACC_STRDST))) |->
      (mem_req_o && (seg_id_o == SEG_ES) && (offset_o == $past(di_i))));

  p_no_mem_r10: assert property (@(posedge clk_i) disable iff (!rst_sync_ni)
    (armed_q && $past(req_i && (acc_i == ACC_DATA) && (mode_i <= 3'd1))) |->
      (!mem_req_o && (phys_o == '0) && (offset_o == '0)));

  p_latency_r11: assert property (@(posedge clk_i) disable iff (!rst_sync_ni)
    armed_q |-> (valid_o == $past(req_i)));

  p_memreq_valid_r11: assert property (@(posedge clk_i) disable iff (!rst_sync_ni)
    mem_req_o |-> valid_o);

  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_sync_ni)
    (armed_q && !$past(req_i)) |->
      ($stable(offset_o) && $stable(phys_o) && $stable(seg_id_o) && $stable(seg_val_o)));

  p_reset_clear_r12: assert property (@(posedge clk_i)
    !rst_sync_ni |-> (!valid_o && !mem_req_o && (phys_o == '0) && (offset_o == '0)));

endmodule

bind rm_addr_gen rm_addr_gen_chk #(.OFS_W(OFS_W), .SEG_SHIFT(SEG_SHIFT)) u_chk (
  .clk_i       (clk_i),
  .rst_sync_ni (rst_sync_n),
  .req_i       (req_i),
  .acc_i       (acc_i),
  .mode_i      (mode_i),
  .ip_i        (ip_i),
  .sp_i        (sp_i),
  .di_i        (di_i),
  .valid_o     (valid_o),
  .mem_req_o   (mem_req_o),
  .offset_o    (offset_o),
  .seg_id_o    (seg_id_o),
  .seg_val_o   (seg_val_o),
  .phys_o      (phys_o)
);

// File: tb/rm_addr_gen_bench.sv
`timescale 1ns/1ps
module rm_addr_gen_bench;

  typedef struct packed {
    logic        mem;
    logic [15:0] ofs;
    logic [1:0]  sid;
    logic [15:0] sval;
    logic [19:0] pa;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req;
  logic [1:0]  acc;
  logic [2:0]  mode;
  logic        base_bp, idx_di, ind_idx, disp_wide, ovr_en;
  logic [1:0]  ovr_sel;
  logic [15:0] disp, bx, bp, si, di, sp, ip, es, cs, ss, ds;
  logic        valid, mem_req;
  logic [15:0] offset, seg_val;
  logic [1:0]  seg_id;
  logic [19:0] phys;

  int   checks = 0;
  int   errors = 0;
  bit   done   = 0;
  exp_t last;

  always #2 clk = ~clk;

  rm_addr_gen u_rm_addr_gen (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .acc_i(acc), .mode_i(mode),
    .base_bp_i(base_bp), .idx_di_i(idx_di), .ind_idx_i(ind_idx),
    .disp_i(disp), .disp_wide_i(disp_wide),
    .bx_i(bx), .bp_i(bp), .si_i(si), .di_i(di), .sp_i(sp), .ip_i(ip),
    .es_i(es), .cs_i(cs), .ss_i(ss), .ds_i(ds),
    .ovr_en_i(ovr_en), .ovr_sel_i(ovr_sel),
    .valid_o(valid), .mem_req_o(mem_req), .offset_o(offset),
    .seg_id_o(seg_id), .seg_val_o(seg_val), .phys_o(phys)
  );

  function automatic exp_t model();
    exp_t        e;
    logic [15:0] d, b, x;
    logic        bpref;
    logic [19:0] sb, ob;
    e     = '0;
    bpref = 1'b0;
    d = disp_wide ? disp : {{8{disp[7]}}, disp[7:0]};
    b = base_bp ? bp : bx;
    x = idx_di ? di : si;
    e.mem = 1'b1;
    case (acc)
      2'd0: begin e.ofs = ip; e.sid = 2'd1; end
      2'd1: begin e.ofs = sp; e.sid = 2'd2; end
      2'd3: begin e.ofs = di; e.sid = 2'd0; end
      default: begin
        case (mode)
          3'd0, 3'd1: e.mem = 1'b0;
          3'd2: e.ofs = d;
          3'd3: begin e.ofs = ind_idx ? x : b; bpref = !ind_idx && base_bp; end
          3'd4: begin e.ofs = b + d; bpref = base_bp; end
          3'd5: e.ofs = x + d;
          3'd6: begin e.ofs = b + x; bpref = base_bp; end
          default: begin e.ofs = b + x + d; bpref = base_bp; end
        endcase
        e.sid = ovr_en ? ovr_sel : (bpref ? 2'd2 : 2'd3);
      end
    endcase
    case (e.sid)
      2'd0: e.sval = es;
      2'd1: e.sval = cs;
      2'd2: e.sval = ss;
      default: e.sval = ds;
    endcase
    sb   = {e.sval, 4'h0};
    ob   = {4'h0, e.ofs};
    e.pa = sb + ob;
    if (!e.mem) e = '0;
    return e;
  endfunction

  task automatic txn(input string tag);
    exp_t e;
    e   = model();
    req = 1'b1;
    @(negedge clk);
    req = 1'b0;
    checks++;
    if (!valid || mem_req !== e.mem || offset !== e.ofs || seg_id !== e.sid ||
        seg_val !== e.sval || phys !== e.pa) begin
      errors++;
      $display("FAIL %s: actual v=%0b m=%0b ofs=%h sid=%0d seg=%h pa=%h expected v=1 m=%0b ofs=%h sid=%0d seg=%h pa=%h",
               tag, valid, mem_req, offset, seg_id, seg_val, phys,
               e.mem, e.ofs, e.sid, e.sval, e.pa);
    end
    last = e;
  endtask

  task automatic randomize_inputs();
    acc = 2'($urandom); mode = 3'($urandom);
    base_bp = 1'($urandom); idx_di = 1'($urandom); ind_idx = 1'($urandom);
    disp_wide = 1'($urandom); ovr_en = 1'($urandom); ovr_sel = 2'($urandom);
    disp = 16'($urandom); bx = 16'($urandom); bp = 16'($urandom);
    si = 16'($urandom); di = 16'($urandom); sp = 16'($urandom); ip = 16'($urandom);
    es = 16'($urandom); cs = 16'($urandom); ss = 16'($urandom); ds = 16'($urandom);
  endtask

  // R11: an idle cycle with changed inputs leaves the held result untouched.
  task automatic idle_check();
    req = 1'b0;
    randomize_inputs();
    @(negedge clk);
    checks++;
    if (valid || mem_req || offset !== last.ofs || seg_id !== last.sid ||
        seg_val !== last.sval || phys !== last.pa) begin
      errors++;
      $display("FAIL R11 hold: actual v=%0b m=%0b ofs=%h sid=%0d seg=%h pa=%h expected v=0 m=0 ofs=%h sid=%0d seg=%h pa=%h",
               valid, mem_req, offset, seg_id, seg_val, phys,
               last.ofs, last.sid, last.sval, last.pa);
    end
  endtask

  task automatic zero_check(input string tag);
    checks++;
    if (valid || mem_req || offset !== 16'h0 || seg_id !== 2'd0 ||
        seg_val !== 16'h0 || phys !== 20'h0) begin
      errors++;
      $display("FAIL %s reset: actual v=%0b m=%0b ofs=%h sid=%0d seg=%h pa=%h expected all zero",
               tag, valid, mem_req, offset, seg_id, seg_val, phys);
    end
  endtask

  task automatic clear_inputs();
    req = 0; acc = 0; mode = 0; base_bp = 0; idx_di = 0; ind_idx = 0;
    disp_wide = 1; ovr_en = 0; ovr_sel = 0; disp = 0;
    bx = 0; bp = 0; si = 0; di = 0; sp = 0; ip = 0;
    es = 0; cs = 0; ss = 0; ds = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R11 watchdog: actual=timeout expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    clear_inputs();
    repeat (3) @(negedge clk);
    zero_check("R12");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: C000h:1C78h
    clear_inputs(); acc = 2; mode = 3'd2; disp = 16'h1C78; ds = 16'hC000;
    txn("R1 C000:1C78");
    // R1: FFFFh:0010h wraps to zero
    disp = 16'h0010; ds = 16'hFFFF;
    txn("R1 wrap20");
    // R2: F000h+3000h wraps to 2000h, DS 4000h
    mode = 3'd4; bx = 16'hF000; disp = 16'h3000; ds = 16'h4000;
    txn("R2 wrap16");
    // R4: short displacement FEh means -2, upper byte ignored
    bx = 16'h0010; disp = 16'hAAFE; disp_wide = 0;
    txn("R4 sext");
    disp = 16'h007F;
    txn("R4 positive");
    // R8: BP base defaults to SS
    disp_wide = 1; base_bp = 1; bp = 16'h0100; disp = 16'h0004;
    ss = 16'h2222; ds = 16'h3333; es = 16'h1111; cs = 16'h4444;
    txn("R8 bp->SS");
    // R9: override to ES
    ovr_en = 1; ovr_sel = 2'd0;
    txn("R9 ovr ES");
    // R5/R6/R7 ignore the override
    ip = 16'h1234; sp = 16'hFFFE; di = 16'h0042;
    acc = 0; txn("R5 fetch");
    acc = 1; txn("R6 stack");
    acc = 3; txn("R7 strdst");
    idle_check();
    // R10: register and immediate modes
    acc = 2; ovr_en = 0; mode = 3'd0; txn("R10 reg");
    mode = 3'd1; txn("R10 imm");
    // R3: each memory mode
    bx = 16'h1000; bp = 16'h2000; si = 16'h0300; di = 16'h0040; disp = 16'h0005;
    base_bp = 0; idx_di = 0;
    for (int m = 2; m < 8; m++) begin
      mode = 3'(m);
      ind_idx = 1'(m & 1);
      txn("R3 mode");
    end
    idle_check();
    // R12: reset mid-run clears outputs asynchronously
    rst_n = 1'b0;
    #1;
    zero_check("R12 mid");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int i = 0; i < 3000; i++) begin
      randomize_inputs();
      if (($urandom % 4) == 0) idle_check();
      else txn("R3 R8 R9 random");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule